// File: doc/BRIEF.md
# Codec Serial Control Write Engine

This block pushes single register writes into one of two audio codec chips over a three-wire serial control link: a serial data line, a serial clock line and two active-low chip selects, one per codec. The host presents a chip index, a 5-bit register address and an 8-bit data byte, and pulses a start strobe. The engine builds a 16-bit frame and shifts it out most significant bit first. Every step of the bit cycle is followed by a programmable wait. When the frame is done, the engine puts all lines back to their idle level and reports completion.

The data and clock pins are shared with other functions on the board. For that reason the engine drives them only while a transfer runs, and it flags this with an output enable. The pad logic outside the block uses that enable to tri-state the pins between transfers. The chip selects are dedicated and always driven, and they idle high. The wait length is a parameter in system clock cycles. Its default is 100 µs at a 100 MHz clock.

Top module: `codec_ctl_writer`

## Requirements
- R1: A frame is 16 bits. Bits 15:14 carry the fixed device code 2'b10. Bit 13 is 1 and marks a write. Bits 12:8 carry the register address and bits 7:0 carry the data byte.
- R2: Each frame produces exactly 16 rising edges of the serial clock while a chip select is low. Bits go out most significant first, and the data line is steady across each rising edge.
- R3: Each bit takes three steps, each lasting WAIT_CYCLES clock cycles. First the clock goes low, then the data line takes the new bit, then the clock goes high. The clock is therefore low for 2×WAIT_CYCLES cycles per bit, and the data line changes only while the clock is low.
- R4: Once a start is accepted, the drive enable rises, and data, clock and both selects stay high for WAIT_CYCLES cycles. Only after that does one select fall.
- R5: Chip index 0 pulls select 0 low. Indices 1, 2 and 3 pull select 1 low. The two selects are never low together.
- R6: A start with chip index 4 to 7 is rejected. No transfer begins, busy stays low, the selects stay high and no done pulse appears.
- R7: After the 16th bit, both selects and the data line return high in the same cycle, with the clock high. This idle state holds for WAIT_CYCLES cycles.
- R8: A start pulse that arrives while busy is high is ignored. The running frame is not altered and no second frame follows.
- R9: When the final idle wait ends, done is high for exactly one cycle, WAIT_CYCLES cycles after the selects rise. Busy is low in that cycle.
- R10: The drive enable is high whenever a select is low, and it is low in the cycle after done.
- R11: During reset, busy, done and drive enable are low and both selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a frame |
| chip_idx_i | input | IDX_W | Target codec index; values of NUM_CHIPS and above are rejected |
| reg_addr_i | input | 5 | Codec register address |
| wr_data_i | input | 8 | Byte to write |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| sdata_o | output | 1 | Serial data line value |
| sclk_o | output | 1 | Serial clock line value |
| drive_en_o | output | 1 | Output enable for the shared data and clock pins |
| cs0_n_o | output | 1 | Active-low select for codec 0 |
| cs1_n_o | output | 1 | Active-low select for codec 1 |

## Verification
A wrong shift register or bit counter shows up when the chip select rises: the captured word differs from the expected one, or it does not hold exactly 16 bits. A stuck or skipping phase state shows up at the very next clock edge on the link. The clock-low run length is measured at every rising edge of the serial clock, and a data change while the clock is high is caught in the cycle it happens. A bad acceptance decision leaks out as activity on the selects within one wait period, or as an extra frame that has nothing left in the queue to match.

// File: rtl/ccw_pkg.sv
// Shared widths, frame constants and the phase encoding for the codec
// serial control write engine. Assumes a fixed 16-bit write frame.
package ccw_pkg;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 8;
    localparam int DEV_W   = 2;
    localparam int FRAME_W = DEV_W + 1 + REG_W + DATA_W;
    localparam int BIT_W   = $clog2(FRAME_W);

    localparam logic [DEV_W-1:0] DEV_CODE = 2'b10;
    localparam logic             WR_FLAG  = 1'b1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SEL,
        ST_CLK_LO,
        ST_SET_D,
        ST_CLK_HI,
        ST_FIN
    } ccw_state_t;
endpackage

// File: rtl/ccw_frame_build.sv
// Assembles the write frame from the host fields and classifies the chip
// index. Purely combinational; assumes fields are stable while start_i is high.
module ccw_frame_build
    import ccw_pkg::*;
#(
    parameter int IDX_W     = 3,
    parameter int NUM_CHIPS = 4
) (
    input  logic [IDX_W-1:0]   chip_idx_i,
    input  logic [REG_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               idx_ok_o,
    output logic               sel_hi_o
);
    localparam logic [IDX_W:0] IDX_LIMIT = NUM_CHIPS[IDX_W:0];

    // Frame layout: device code, write flag, register address, data.
    always_comb begin
        frame_o = {DEV_CODE, WR_FLAG, reg_addr_i, wr_data_i};
    end

    // Index check and select choice: index 0 uses select 0, others select 1.
    always_comb begin
        idx_ok_o = ({1'b0, chip_idx_i} < IDX_LIMIT);
        sel_hi_o = (chip_idx_i != '0);
    end
endmodule

// File: rtl/ccw_phase_timer.sv
// Free-running wait counter for the bit-cycle phases. While run_i is high it
// counts 0..WAIT_CYCLES-1 and wraps, pulsing tick_o on the last count.
// Each phase therefore lasts exactly WAIT_CYCLES cycles. Assumes WAIT_CYCLES >= 1.
module ccw_phase_timer #(
    parameter int WAIT_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] count_q;

    // Count while running, wrap at the end of each phase, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            count_q <= '0;
        end else if (count_q == LAST) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // End-of-phase strobe.
    always_comb begin
        tick_o = run_i && (count_q == LAST);
    end

    // Counter must never pass the last phase count (phase length, R3).
    p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST);
endmodule

// File: rtl/ccw_sequencer.sv
// Phase sequencer and shifter. Accepts a start only when idle with a valid
// index. It then walks through: all-high prelude, select, and per bit
// clock-low / data-set / clock-high, then an all-high finish. Each phase
// lasts one timer period. Assumes tick_i comes from a timer that runs while busy.
module ccw_sequencer
    import ccw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               idx_ok_i,
    input  logic               sel_hi_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               tick_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               sdata_o,
    output logic               sclk_o,
    output logic               drive_en_o,
    output logic               cs0_n_o,
    output logic               cs1_n_o
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    ccw_state_t         state_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [BIT_W-1:0]   bit_cnt_q;
    logic               sdata_q;
    logic               sel_q;
    logic               done_q;
    logic               sel_active;

    // Phase walk, shift register and data line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            sdata_q   <= 1'b1;
            sel_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i && idx_ok_i) begin
                        state_q   <= ST_PRE;
                        shreg_q   <= frame_i;
                        sel_q     <= sel_hi_i;
                        bit_cnt_q <= '0;
                        sdata_q   <= 1'b1;
                    end
                end
                ST_PRE: begin
                    if (tick_i) state_q <= ST_SEL;
                end
                ST_SEL: begin
                    if (tick_i) state_q <= ST_CLK_LO;
                end
                ST_CLK_LO: begin
                    if (tick_i) begin
                        state_q <= ST_SET_D;
                        sdata_q <= shreg_q[FRAME_W-1];
                    end
                end
                ST_SET_D: begin
                    if (tick_i) state_q <= ST_CLK_HI;
                end
                ST_CLK_HI: begin
                    if (tick_i) begin
                        shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                        if (bit_cnt_q == LAST_BIT) begin
                            state_q <= ST_FIN;
                            sdata_q <= 1'b1;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            state_q   <= ST_CLK_LO;
                        end
                    end
                end
                ST_FIN: begin
                    if (tick_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Line decode from the current phase.
    always_comb begin
        sel_active = (state_q == ST_SEL) || (state_q == ST_CLK_LO) ||
                     (state_q == ST_SET_D) || (state_q == ST_CLK_HI);
        busy_o     = (state_q != ST_IDLE);
        done_o     = done_q;
        drive_en_o = busy_o;
        sdata_o    = sdata_q;
        sclk_o     = !((state_q == ST_CLK_LO) || (state_q == ST_SET_D));
        cs0_n_o    = !(sel_active && !sel_q);
        cs1_n_o    = !(sel_active && sel_q);
    end

    // Data must be steady across a rising clock edge (R2).
    p_data_steady_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdata_o));

    // With a select low, data may change only while the clock is low (R3).
    p_data_moves_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdata_o) && !(cs0_n_o && cs1_n_o)) |-> !sclk_o);

    // A select falls only after all lines sat high (R4).
    p_prelude_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs0_n_o) || $fell(cs1_n_o)) |-> ($past(sdata_o) && $past(sclk_o) &&
                                                 $past(cs0_n_o) && $past(cs1_n_o)));

    // Never both selects at once (R5).
    p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n_o || cs1_n_o));

    // Release: selects rise together with data and clock high (R7).
    p_release_all_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs0_n_o) || $rose(cs1_n_o)) |-> (sdata_o && sclk_o && cs0_n_o && cs1_n_o));

    // Done lasts one cycle and comes right after a busy cycle (R9).
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // Pins are driven whenever a select is low (R10).
    p_drive_while_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs0_n_o && cs1_n_o) |-> drive_en_o);
endmodule

// File: rtl/codec_ctl_writer.sv
// Top of the codec serial control write engine. Ties together the frame
// builder, the phase timer and the sequencer. Assumes host fields are valid
// in the start cycle; data/clock pins are tri-stated outside when
// drive_en_o is low.
module codec_ctl_writer
    import ccw_pkg::*;
#(
    parameter int WAIT_CYCLES = 10000,
    parameter int IDX_W       = 3,
    parameter int NUM_CHIPS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  chip_idx_i,
    input  logic [REG_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sdata_o,
    output logic              sclk_o,
    output logic              drive_en_o,
    output logic              cs0_n_o,
    output logic              cs1_n_o
);
    localparam logic [IDX_W:0] IDX_LIMIT = NUM_CHIPS[IDX_W:0];

    logic [FRAME_W-1:0] frame;
    logic               idx_ok;
    logic               sel_hi;
    logic               tick;

    ccw_frame_build #(
        .IDX_W     (IDX_W),
        .NUM_CHIPS (NUM_CHIPS)
    ) u_build (
        .chip_idx_i (chip_idx_i),
        .reg_addr_i (reg_addr_i),
        .wr_data_i  (wr_data_i),
        .frame_o    (frame),
        .idx_ok_o   (idx_ok),
        .sel_hi_o   (sel_hi)
    );

    ccw_phase_timer #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    ccw_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .idx_ok_i   (idx_ok),
        .sel_hi_i   (sel_hi),
        .frame_i    (frame),
        .tick_i     (tick),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .sdata_o    (sdata_o),
        .sclk_o     (sclk_o),
        .drive_en_o (drive_en_o),
        .cs0_n_o    (cs0_n_o),
        .cs1_n_o    (cs1_n_o)
    );

    // An out-of-range index seen while idle starts nothing (R6).
    p_reject_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && ({1'b0, chip_idx_i} >= IDX_LIMIT)) |=> !busy_o);

    // A start seen while busy does not restart: busy stays up (R8).
    p_start_busy_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o && $past(busy_o)) |=> (busy_o || done_o));
endmodule

// File: tb/codec_ctl_writer_test.sv
module codec_ctl_writer_test;
    localparam int WAIT = 3;

    typedef struct packed {
        logic        sel;
        logic [15:0] word;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] chip_idx_i = '0;
    logic [4:0] reg_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic busy_o, done_o, sdata_o, sclk_o, drive_en_o, cs0_n_o, cs1_n_o;

    always #5 clk = ~clk;

    codec_ctl_writer #(.WAIT_CYCLES(WAIT)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chip_idx_i(chip_idx_i),
        .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i), .busy_o(busy_o),
        .done_o(done_o), .sdata_o(sdata_o), .sclk_o(sclk_o),
        .drive_en_o(drive_en_o), .cs0_n_o(cs0_n_o), .cs1_n_o(cs1_n_o)
    );

    int   n_checks = 0;
    int   n_fails = 0;
    bit   finished = 0;
    exp_t exp_q[$];
    int   frames_seen = 0;
    int   frames_pushed = 0;
    int   done_cnt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    // Monitor: rebuilds frames from the pins and scores them against the queue.
    int          cyc = 0;
    int          t_en = 0, t_lo = 0, t_csr = 0;
    logic        p_den = 0, p_sclk = 1, p_sdata = 1, p_cs0 = 1, p_cs1 = 1, p_done = 0;
    bit          in_pre = 0, pre_bad = 0, hi_bad = 0;
    logic [15:0] word = '0;
    int          nbits = 0;
    logic        cur_sel = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!(cs0_n_o && cs1_n_o) && !drive_en_o)
                chk(0, "R10 pins not driven with select low", drive_en_o, 1);
            if (!cs0_n_o && !cs1_n_o)
                chk(0, "R5 both selects low", 0, 1);
            if (drive_en_o && !p_den) begin
                t_en = cyc; in_pre = 1; pre_bad = 0;
            end
            if (in_pre && cs0_n_o && cs1_n_o && !(sdata_o && sclk_o))
                pre_bad = 1;
            if (p_cs0 && p_cs1 && !(cs0_n_o && cs1_n_o)) begin
                in_pre = 0;
                chk(cyc - t_en == WAIT, "R4 prelude length", cyc - t_en, WAIT);
                chk(!pre_bad, "R4 lines high in prelude", pre_bad, 0);
                cur_sel = !cs1_n_o; word = '0; nbits = 0; hi_bad = 0;
            end
            if (!(cs0_n_o && cs1_n_o)) begin
                if (p_sclk && !sclk_o) t_lo = cyc;
                if (!p_sclk && sclk_o) begin
                    chk(cyc - t_lo == 2 * WAIT, "R3 clock low length", cyc - t_lo, 2 * WAIT);
                    chk(sdata_o == p_sdata, "R2 data steady at rise", sdata_o, p_sdata);
                    word = {word[14:0], sdata_o};
                    nbits++;
                end
                if (p_sclk && sclk_o && (sdata_o != p_sdata)) hi_bad = 1;
            end
            if (!(p_cs0 && p_cs1) && cs0_n_o && cs1_n_o) begin
                t_csr = cyc;
                frames_seen++;
                chk(sdata_o && sclk_o, "R7 all lines high at release", {sdata_o, sclk_o}, 3);
                chk(!hi_bad, "R3 data moved with clock high", hi_bad, 0);
                chk(nbits == 16, "R2 rising edges per frame", nbits, 16);
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected frame", word, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(word == e.word, "R1 frame word", word, e.word);
                    chk(cur_sel == e.sel, "R5 select used", cur_sel, e.sel);
                end
            end
            if (done_o) begin
                done_cnt++;
                chk(cyc - t_csr == WAIT, "R9 done after final wait", cyc - t_csr, WAIT);
                chk(!busy_o, "R9 busy low at done", busy_o, 0);
                if (!(cs0_n_o && cs1_n_o && sdata_o && sclk_o))
                    chk(0, "R7 idle held until done", 0, 1);
            end
            if (p_done) begin
                chk(!done_o, "R9 done one cycle", done_o, 0);
                chk(!drive_en_o, "R10 drive released after done", drive_en_o, 0);
            end
        end
        p_den = drive_en_o; p_sclk = sclk_o; p_sdata = sdata_o;
        p_cs0 = cs0_n_o; p_cs1 = cs1_n_o; p_done = done_o;
    end

    // Driver: pulses start and queues the expected frame for valid indices.
    task automatic send(input logic [2:0] chip, input logic [4:0] addr, input logic [7:0] data);
        @(negedge clk);
        chip_idx_i = chip; reg_addr_i = addr; wr_data_i = data; start_i = 1'b1;
        if (chip < 4) begin
            exp_t e;
            e.sel  = (chip != 0);
            e.word = {2'b10, 1'b1, addr, data};
            exp_q.push_back(e);
            frames_pushed++;
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int d0;
        d0 = done_cnt;
        while (done_cnt == d0) @(negedge clk);
    endtask

    task automatic quiet_window(input string tag, input int cycles);
        bit moved;
        int d0;
        moved = 0;
        d0 = done_cnt;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy_o || !cs0_n_o || !cs1_n_o || drive_en_o) moved = 1;
        end
        chk(!moved && done_cnt == d0, tag, moved, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !drive_en_o && cs0_n_o && cs1_n_o, "R11 reset state",
            {busy_o, done_o, drive_en_o, cs0_n_o, cs1_n_o}, 5'b00011);
        rst_n = 1'b1;

        send(3'd0, 5'h02, 8'hA5); wait_done();
        send(3'd1, 5'h1F, 8'h00); wait_done();
        send(3'd2, 5'h00, 8'hFF); wait_done();
        send(3'd3, 5'h15, 8'h3C); wait_done();

        // R6: out-of-range indices start nothing
        send(3'd4, 5'h0A, 8'h55);
        quiet_window("R6 index 4 rejected", 4 * WAIT);
        send(3'd7, 5'h11, 8'h99);
        quiet_window("R6 index 7 rejected", 4 * WAIT);
        send(3'd0, 5'h0C, 8'h6E); wait_done();

        // R8: starts while busy are ignored
        send(3'd1, 5'h03, 8'h11);
        repeat (20) @(negedge clk);
        chip_idx_i = 3'd0; reg_addr_i = 5'h1E; wr_data_i = 8'hEE; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (40) @(negedge clk);
        chip_idx_i = 3'd2; reg_addr_i = 5'h07; wr_data_i = 8'h42; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_done();
        quiet_window("R8 no second frame after busy start", 4 * WAIT);
        chk(frames_seen == frames_pushed, "R8 frame count", frames_seen, frames_pushed);
        chk(exp_q.size() == 0, "R1 all expected frames seen", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule